// File: doc/BRIEF.md
# Serial-Loaded 10-Bit DAC Input Front End

This block is the digital side of a serially programmed 10-bit voltage DAC. A host drives three wires: an active-low select, a serial clock and a serial data line. While the select is low, every rising serial clock edge pushes one data bit into a 16-bit shift register, most significant bit first. When the select returns high, the ten code bits are copied from a fixed window of the shift register into a holding register. That holding register drives the parallel code toward the resistor-string core. Code 0x000 means zero output and 0x3FF means full scale. The analog level is code/1024 of twice the reference, with the same polarity as the reference.

The data window lies just above the two lowest register bits. Because of that, a 12-bit frame (ten code bits and then two sub-LSB bits) and a 16-bit frame (four dummy bits first) give the same code. A cascade output launches the top register bit on each falling serial clock edge, so a second device wired behind this one receives the first bit that was sent once 16 bits have passed. All three wires are asynchronous to the fast system clock. They go through synchronizers, and their edges become one-cycle strobes. The serial master alone sets the pace, so there is no valid/ready pair and no back-pressure: a transfer can never be refused or held off. The parallel code is a level, and it changes only at a transfer.

Top module: `serdac_front`

## Requirements
- R1: While the select is low, each rising serial clock edge shifts the data line into bit 0 of the 16-bit shift register, and all older bits move up by one position. The first bit sent ends up highest.
- R2: While the select is high, serial clock edges leave the shift register unchanged. A later frame with no clock edges then reloads the previous code.
- R3: On each rising edge of the select, register bits 11 down to 2 are copied into the 10-bit code output, with bit 11 as the code MSB.
- R4: In a 16-bit frame, the four leading dummy bits and the two trailing sub-LSB bits have no effect on the code output.
- R5: A 12-bit frame made of ten code bits and two sub-LSB bits gives the same code as the matching 16-bit frame.
- R6: On each falling serial clock edge while the select is low, the cascade output takes register bit 15. After a 16-bit frame it equals the first bit of that frame.
- R7: An active-low reset clears the shift register, the code output and the cascade output to zero.
- R8: The code output stays at its previous value for the whole frame, until the select rises.
- R9: The code output shows a new value no more than 4 system clocks after the select rises. The cascade output follows a falling serial clock edge within 3 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| sel_n_i | input | 1 | Active-low select from the serial host |
| sck_i | input | 1 | Serial clock from the host |
| sdat_i | input | 1 | Serial data, MSB first |
| casc_o | output | 1 | Cascade output for the next device |
| code_o | output | 10 | Held DAC code toward the analog core |

## Verification
The hardest states to reach from the ports are those where the shift register holds stale bits: bits left over from an earlier frame, or from clock edges sent while deselected. Neither the code nor the cascade output shows the register directly. The bench therefore follows every frame with an empty select pulse, which has no clock edges and reloads the code from the register. It also sends each frame's bits across the cascade output one by one, so that any lost or extra shift shows up as a wrong bit. A mid-run reset followed by an empty select pulse shows that the register itself was cleared, and not only the code.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned CODE_BITS  = 10;
  localparam int unsigned SUB_BITS   = 2;
  localparam int unsigned SYNC_DEPTH = 2;

  // lane order inside the synchronizer vector
  typedef enum int unsigned {
    LANE_SEL  = 0,
    LANE_SCK  = 1,
    LANE_DAT  = 2,
    LANE_CNT  = 3
  } lane_e;
endpackage

// File: rtl/serdac_pin_sync.sv
module serdac_pin_sync #(
  parameter int unsigned  WIDTH = 3,
  parameter int unsigned  DEPTH = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);
  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
      logic [DEPTH-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {DEPTH{IDLE[g]}};
        else        stg <= {stg[DEPTH-2:0], pin_i[g]};
      end
      assign lvl_o[g] = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
  parameter int unsigned SR_W   = 16,
  parameter int unsigned WIN_LO = 2,
  parameter int unsigned WIN_W  = 10,
  localparam int unsigned WIN_HI = WIN_LO + WIN_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             launch_en,
  input  logic             sdat,
  output logic [WIN_W-1:0] win_o,
  output logic             casc_o
);
  logic [SR_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sreg <= '0;
    else if (shift_en) sreg <= {sreg[SR_W-2:0], sdat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         casc_o <= 1'b0;
    else if (launch_en) casc_o <= sreg[SR_W-1];
  end

  assign win_o = sreg[WIN_HI:WIN_LO];

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sreg));

  p_casc_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_o != $past(casc_o)) |-> $past(launch_en));
endmodule

// File: rtl/serdac_hold.sv
module serdac_hold #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [CODE_W-1:0] nxt_code,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_o <= '0;
    else if (xfer) code_o <= nxt_code;
  end

  p_code_only_on_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != $past(code_o)) |-> $past(xfer));
endmodule

// File: rtl/serdac_front.sv
module serdac_front
  import serdac_pkg::*;
#(
  parameter int unsigned SR_W   = FRAME_BITS,
  parameter int unsigned CODE_W = CODE_BITS,
  parameter int unsigned SUB_W  = SUB_BITS,
  parameter int unsigned SYNC_N = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sck_i,
  input  logic              sdat_i,
  output logic              casc_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned NLANE = LANE_CNT;
  localparam logic [NLANE-1:0] IDLE_LVL = NLANE'(1) << LANE_SEL;

  logic [NLANE-1:0] raw, lvl;
  logic             sel_q, sck_q;
  logic             sck_rise, sck_fall, sel_rise, selected;
  logic [CODE_W-1:0] win;

  always_comb begin
    raw           = '0;
    raw[LANE_SEL] = sel_n_i;
    raw[LANE_SCK] = sck_i;
    raw[LANE_DAT] = sdat_i;
  end

  serdac_pin_sync #(.WIDTH(NLANE), .DEPTH(SYNC_N), .IDLE(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(raw), .lvl_o(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      sel_q <= lvl[LANE_SEL];
      sck_q <= lvl[LANE_SCK];
    end
  end

  assign selected = ~lvl[LANE_SEL];
  assign sck_rise = lvl[LANE_SCK] & ~sck_q;
  assign sck_fall = ~lvl[LANE_SCK] & sck_q;
  assign sel_rise = lvl[LANE_SEL] & ~sel_q;

  serdac_shifter #(.SR_W(SR_W), .WIN_LO(SUB_W), .WIN_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(sck_rise & selected),
    .launch_en(sck_fall & selected),
    .sdat(lvl[LANE_DAT]),
    .win_o(win),
    .casc_o(casc_o)
  );

  serdac_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .xfer(sel_rise), .nxt_code(win), .code_o(code_o)
  );

  p_xfer_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> (code_o == $past(win)));

  p_no_shift_while_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[LANE_SEL] && sel_q) |=> $stable(win));
endmodule

// File: tb/serdac_front_bench.sv
module serdac_front_bench;
  localparam int CLK_NS = 10;
  localparam int HALF   = 4;
  localparam int LIMIT  = 195000;

  logic clk = 0, rst_n = 0, sel_n = 1, sck = 0, sdat = 0;
  logic casc;
  logic [9:0] code;
  int n_cmp = 0, n_bad = 0;
  logic [15:0] hist = '0;
  logic [9:0] last_code = '0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  serdac_front u_serdac_front (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck), .sdat_i(sdat),
    .casc_o(casc), .code_o(code)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: data and clock rise together, then fall; casc checked after the fall
  task automatic send_bit(input logic b, input bit sel_on);
    sdat = b; sck = 1; wait_n(HALF);
    sck = 0; wait_n(HALF);
    if (sel_on) begin
      hist = {hist[14:0], b};
      check("R6 cascade bit after falling edge (R1 order)", casc, hist[15]);
    end
  endtask

  task automatic frame(input logic [15:0] word, input int nbits, input logic [9:0] exp);
    sel_n = 0; wait_n(HALF);
    for (int i = nbits - 1; i >= 0; i--) send_bit(word[i], 1);
    wait_n(HALF);
    check("R8 code held during frame", code, last_code);
    sel_n = 1;
    wait_n(4);
    check("R9/R3 code after select rise", code, exp);
    last_code = exp;
    wait_n(2);
  endtask

  initial begin
    wait_n(4);
    check("R7 reset code", code, 0);
    check("R7 reset cascade", casc, 0);
    rst_n = 1;
    wait_n(3);

    // sweep every code: even ones as 16-bit frames, odd ones as 12-bit frames
    for (int c = 0; c < 1024; c++) begin
      logic [9:0] cv = 10'(c);
      if (c % 2 == 0) begin
        frame({cv[3:0] ^ 4'ha, cv, cv[1:0] ^ 2'b01}, 16, cv);   // R4 dummies/sub-LSB ignored
        check("R6 cascade equals first bit of 16-bit frame", casc, cv[3] ^ 1'b1);
      end else begin
        frame({4'h0, cv, ~cv[1:0]}, 12, cv);                    // R5 12-bit frame
      end
    end

    // R4 extremes with opposite dummies
    frame({4'hf, 10'h000, 2'b11}, 16, 10'h000);
    frame({4'h0, 10'h3ff, 2'b00}, 16, 10'h3ff);
    frame({4'h5, 10'h200, 2'b10}, 16, 10'h200);

    // R2: clocks while deselected, then empty frame reloads same code
    for (int k = 0; k < 7; k++) send_bit(k[0], 0);
    frame(16'h0, 0, 10'h200);
    check("R2 cascade unchanged while deselected", casc, hist[15]);

    // R5 vs R4: same code both formats back to back
    frame({4'h9, 10'h155, 2'b01}, 16, 10'h155);
    frame({4'h0, 10'h2aa, 2'b10}, 12, 10'h2aa);

    // R7: reset mid-run clears register too
    wait_n(1);
    rst_n = 0; wait_n(3);
    check("R7 code cleared by reset", code, 0);
    check("R7 cascade cleared by reset", casc, 0);
    rst_n = 1; wait_n(3);
    hist = '0; last_code = '0;
    frame(16'h0, 0, 10'h000);   // R7 empty frame shows cleared shift register

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule